// File: doc/BRIEF.md
# Buffer release descriptor dispatcher

This block takes release descriptors, one per valid/ready handshake, and decides where each released buffer or descriptor must go. A descriptor carries a 40-bit address, a 4-bit owner (return-manager) code, an action code, a buffer-type code, an override-valid bit and a 4-bit override code. From these fields the block picks one of fourteen destinations and presents the descriptor on that destination's valid/ready pair. The destinations are the idle buffer list, four idle link-descriptor lists (one per chip), the firmware ring, seven software rings and an error ring.

The routing decision is registered in a single holding stage. The descriptor leaves unchanged except for an internal-error flag, which is raised only on entries sent to the error ring. A new input is taken in the same cycle that the held entry drains, so a stream of descriptors to ready outputs moves at one per cycle. Walking link descriptors, memory access and ring pointers are handled elsewhere.

Top module: `rel_dispatch`

## Requirements
- R1: Owner code 0 with type 0 (plain buffer) and action 0 (recycle) goes to destination 0 (idle buffer list) with the error flag clear.
- R2: Owner codes 1, 2, 3 and 12 select the link-descriptor lists of chips 0, 1, 2 and 3 (destinations 1 to 4) when the type is a link kind (1 data link, 2 frame link, 4 queue extension). Action 0 is accepted with every link kind, action 1 only with type 1 and action 2 only with type 2.
- R3: Owner code 4 goes to the firmware ring (destination 5). Codes 5 to 11 go to software rings 0 to 6 (destinations 6 to 12). For these codes the action and the link/buffer type are not checked.
- R4: Type 3 (extension descriptor) always goes to the firmware ring, whatever the owner code, unless R7 applies.
- R5: When the override-valid bit is 1, the override code takes the place of the owner code in all routing. When it is 0, the override code has no effect.
- R6: A plain buffer with action 1 or 2, a plain buffer aimed at a link list, a link kind aimed at the buffer list, and a link-list action that does not match the type (R2) all go to destination 13 (error ring) with the error flag set.
- R7: An effective owner code of 13 to 15, an action of 3 to 7 or a type of 5 to 7 goes to the error ring with the error flag set. This check takes priority over R4.
- R8: The address, owner code, action, type, override bit and override code appear unchanged at the output. The error flag is 1 exactly when the destination is 13.
- R9: in_ready is high when no entry is held or when the held entry's ready is high. An accepted entry is presented in the next cycle on exactly one out_valid bit, and out_dest gives that bit's index.
- R10: While the selected ready is low, the held entry and its valid stay stable and in_ready stays low. Every entry is delivered once, in order of acceptance.
- R11: After reset no out_valid bit is set and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor taken this cycle when in_valid is high |
| in_addr | input | 40 | Address of released buffer or descriptor |
| in_mgr | input | 4 | Owner (return-manager) code |
| in_action | input | 3 | Action code |
| in_btype | input | 3 | Buffer or descriptor type |
| in_ovr_valid | input | 1 | Override code replaces owner code |
| in_ovr_code | input | 4 | Override owner code |
| out_valid | output | 14 | One valid per destination |
| out_ready | input | 14 | One ready per destination |
| out_dest | output | 4 | Index of the selected destination |
| out_addr | output | 40 | Forwarded address |
| out_mgr | output | 4 | Forwarded owner code |
| out_action | output | 3 | Forwarded action |
| out_btype | output | 3 | Forwarded type |
| out_ovr_valid | output | 1 | Forwarded override bit |
| out_ovr_code | output | 4 | Forwarded override code |
| out_err | output | 1 | Internal-error flag |

## Verification
The bench goes after the corners of the decision table. These include extension descriptors addressed to the local buffer list, where a design that checked ownership first would send them to the error ring instead of firmware. They also include chip 3's out-of-sequence code 12, which a linear decoder would misroute, and an override that points a buffer into a link list, which is caught only if the override is applied before the checks. Stuck outputs are tested by holding the firmware ready low while a second entry waits: a design that drops, repeats or reorders the held entry, or that lets in_ready through, shows up as a scoreboard mismatch. A long mixed run with random readies and random codes, including the illegal ones, is compared against a model built from the requirements.

// File: rtl/rdd_pkg.sv
package rdd_pkg;

    localparam int MGR_W    = 4;
    localparam int ACT_W    = 3;
    localparam int TYP_W    = 3;
    localparam int NUM_CHIP = 4;

    localparam logic [MGR_W-1:0] MGR_IDLE_BUF   = 4'd0;
    localparam logic [MGR_W-1:0] MGR_FW         = 4'd4;
    localparam logic [MGR_W-1:0] MGR_SW_FIRST   = 4'd5;
    localparam logic [MGR_W-1:0] MGR_LAST_LEGAL = 4'd12;

    typedef enum logic [ACT_W-1:0] {
        ACT_RECYCLE    = 3'd0,
        ACT_FREE_CHAIN = 3'd1,
        ACT_FREE_DEEP  = 3'd2
    } act_e;

    typedef enum logic [TYP_W-1:0] {
        TY_BUF        = 3'd0,
        TY_DATA_LINK  = 3'd1,
        TY_FRAME_LINK = 3'd2,
        TY_EXT        = 3'd3,
        TY_QUEUE_EXT  = 3'd4
    } btype_e;

    typedef enum logic [2:0] {
        CL_BUF,
        CL_LINK,
        CL_FW,
        CL_SW,
        CL_ERR
    } dclass_e;

    typedef struct packed {
        dclass_e    cls;
        logic [2:0] sub;
    } route_t;

    // chip slot for a link-list owner code; 7 when the code is not a link list
    function automatic logic [2:0] chip_slot(input logic [MGR_W-1:0] code);
        case (code)
            4'd1:    return 3'd0;
            4'd2:    return 3'd1;
            4'd3:    return 3'd2;
            4'd12:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic is_link_kind(input logic [TYP_W-1:0] t);
        return (t == TY_DATA_LINK) || (t == TY_FRAME_LINK) || (t == TY_QUEUE_EXT);
    endfunction

    // Routing decision on the effective owner code
    function automatic route_t classify(input logic [MGR_W-1:0] eff,
                                        input logic [ACT_W-1:0] act,
                                        input logic [TYP_W-1:0] typ);
        route_t r;
        logic [2:0] slot;
        r.cls = CL_ERR;
        r.sub = 3'd0;
        slot  = chip_slot(eff);
        if (eff > MGR_LAST_LEGAL || act > ACT_FREE_DEEP || typ > TY_QUEUE_EXT) begin
            r.cls = CL_ERR;
        end else if (typ == TY_EXT) begin
            r.cls = CL_FW;
        end else if (eff == MGR_IDLE_BUF) begin
            if (typ == TY_BUF && act == ACT_RECYCLE) r.cls = CL_BUF;
        end else if (slot != 3'd7) begin
            if (!is_link_kind(typ))                                 r.cls = CL_ERR;
            else if (act == ACT_FREE_CHAIN && typ != TY_DATA_LINK)  r.cls = CL_ERR;
            else if (act == ACT_FREE_DEEP && typ != TY_FRAME_LINK)  r.cls = CL_ERR;
            else begin
                r.cls = CL_LINK;
                r.sub = slot;
            end
        end else if (eff == MGR_FW) begin
            r.cls = CL_FW;
        end else begin
            r.cls = CL_SW;
            r.sub = 3'(eff - MGR_SW_FIRST);
        end
        return r;
    endfunction

endpackage

// File: rtl/rdd_route.sv
module rdd_route
    import rdd_pkg::*;
#(
    parameter int NUM_SW   = 7,
    parameter int NUM_DEST = 3 + NUM_CHIP + NUM_SW,
    parameter int DEST_W   = $clog2(NUM_DEST)
) (
    input  logic [MGR_W-1:0]  mgr,
    input  logic [ACT_W-1:0]  action,
    input  logic [TYP_W-1:0]  btype,
    input  logic              ovr_valid,
    input  logic [MGR_W-1:0]  ovr_code,
    output logic [DEST_W-1:0] dest,
    output logic              err
);
    localparam logic [DEST_W-1:0] IDX_BUF  = '0;
    localparam logic [DEST_W-1:0] IDX_LINK = DEST_W'(1);
    localparam logic [DEST_W-1:0] IDX_FW   = DEST_W'(1 + NUM_CHIP);
    localparam logic [DEST_W-1:0] IDX_SW   = DEST_W'(2 + NUM_CHIP);
    localparam logic [DEST_W-1:0] IDX_ERR  = DEST_W'(NUM_DEST - 1);

    logic [MGR_W-1:0] eff;
    route_t           rt;

    always_comb begin
        eff = ovr_valid ? ovr_code : mgr;
        rt  = classify(eff, action, btype);
        case (rt.cls)
            CL_BUF:  dest = IDX_BUF;
            CL_LINK: dest = IDX_LINK + DEST_W'(rt.sub);
            CL_FW:   dest = IDX_FW;
            CL_SW:   dest = (int'(rt.sub) < NUM_SW) ? IDX_SW + DEST_W'(rt.sub) : IDX_ERR;
            default: dest = IDX_ERR;
        endcase
        err = (dest == IDX_ERR);
    end

endmodule

// File: rtl/rdd_hold.sv
module rdd_hold #(
    parameter int PAY_W  = 56,
    parameter int DEST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              drain,
    input  logic [DEST_W-1:0] dest_in,
    input  logic [PAY_W-1:0]  pay_in,
    output logic              busy,
    output logic [DEST_W-1:0] dest_q,
    output logic [PAY_W-1:0]  pay_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            dest_q <= '0;
            pay_q  <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            dest_q <= dest_in;
            pay_q  <= pay_in;
        end else if (drain) begin
            busy   <= 1'b0;
        end
    end

endmodule

// File: rtl/rdd_fanout.sv
module rdd_fanout #(
    parameter int NUM_DEST = 14,
    parameter int DEST_W   = 4
) (
    input  logic                busy,
    input  logic [DEST_W-1:0]   dest,
    input  logic [NUM_DEST-1:0] ready,
    output logic [NUM_DEST-1:0] valid,
    output logic                drain
);
    for (genvar i = 0; i < NUM_DEST; i++) begin : g_port
        assign valid[i] = busy && (dest == DEST_W'(i));
    end

    assign drain = |(valid & ready);

endmodule

// File: rtl/rel_dispatch.sv
module rel_dispatch
    import rdd_pkg::*;
#(
    parameter  int ADDR_W   = 40,
    parameter  int NUM_SW   = 7,
    localparam int NUM_DEST = 3 + NUM_CHIP + NUM_SW,
    localparam int DEST_W   = $clog2(NUM_DEST)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [MGR_W-1:0]    in_mgr,
    input  logic [ACT_W-1:0]    in_action,
    input  logic [TYP_W-1:0]    in_btype,
    input  logic                in_ovr_valid,
    input  logic [MGR_W-1:0]    in_ovr_code,
    output logic [NUM_DEST-1:0] out_valid,
    input  logic [NUM_DEST-1:0] out_ready,
    output logic [DEST_W-1:0]   out_dest,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [MGR_W-1:0]    out_mgr,
    output logic [ACT_W-1:0]    out_action,
    output logic [TYP_W-1:0]    out_btype,
    output logic                out_ovr_valid,
    output logic [MGR_W-1:0]    out_ovr_code,
    output logic                out_err
);
    localparam int PAY_W = 1 + MGR_W + 1 + TYP_W + ACT_W + MGR_W + ADDR_W;

    logic [DEST_W-1:0] dec_dest;
    logic              dec_err;
    logic              busy;
    logic              drain;
    logic              load;
    logic [PAY_W-1:0]  pay_d;
    logic [PAY_W-1:0]  pay_q;

    rdd_route #(.NUM_SW(NUM_SW), .NUM_DEST(NUM_DEST), .DEST_W(DEST_W)) u_route (
        .mgr       (in_mgr),
        .action    (in_action),
        .btype     (in_btype),
        .ovr_valid (in_ovr_valid),
        .ovr_code  (in_ovr_code),
        .dest      (dec_dest),
        .err       (dec_err)
    );

    assign in_ready = !busy || drain;
    assign load     = in_valid && in_ready;
    assign pay_d    = {dec_err, in_ovr_code, in_ovr_valid, in_btype, in_action, in_mgr, in_addr};

    rdd_hold #(.PAY_W(PAY_W), .DEST_W(DEST_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .drain   (drain),
        .dest_in (dec_dest),
        .pay_in  (pay_d),
        .busy    (busy),
        .dest_q  (out_dest),
        .pay_q   (pay_q)
    );

    rdd_fanout #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W)) u_fanout (
        .busy  (busy),
        .dest  (out_dest),
        .ready (out_ready),
        .valid (out_valid),
        .drain (drain)
    );

    assign {out_err, out_ovr_code, out_ovr_valid, out_btype, out_action, out_mgr, out_addr} = pay_q;

endmodule

// File: rtl/rel_dispatch_chk.sv
module rel_dispatch_chk #(
    parameter  int ADDR_W   = 40,
    parameter  int NUM_SW   = 7,
    localparam int NUM_DEST = 7 + NUM_SW,
    localparam int DEST_W   = $clog2(NUM_DEST)
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [ADDR_W-1:0]   in_addr,
    input logic [3:0]          in_mgr,
    input logic [2:0]          in_btype,
    input logic [NUM_DEST-1:0] out_valid,
    input logic [NUM_DEST-1:0] out_ready,
    input logic [DEST_W-1:0]   out_dest,
    input logic [ADDR_W-1:0]   out_addr,
    input logic [3:0]          out_mgr,
    input logic [2:0]          out_btype,
    input logic                out_err
);
    localparam int FW_IDX  = 5;
    localparam int ERR_IDX = NUM_DEST - 1;

    logic any_v;
    logic any_x;
    assign any_v = (out_valid != '0);
    assign any_x = ((out_valid & out_ready) != '0);

    a_r9_one_valid: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    a_r9_ready_rule: assert property (@(posedge clk) disable iff (rst)
        in_ready == (!any_v || any_x));

    a_r9_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> any_v);

    a_r9_dest_match: assert property (@(posedge clk) disable iff (rst)
        any_v |-> out_valid[out_dest]);

    a_r8_fields_fwd: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_addr == $past(in_addr)) && (out_mgr == $past(in_mgr))
                                   && (out_btype == $past(in_btype)));

    a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
        any_v |-> (out_err == out_valid[ERR_IDX]));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (any_v && !any_x) |=> $stable(out_valid) && $stable(out_dest) && $stable(out_addr));

    a_r4_ext_fw: assert property (@(posedge clk) disable iff (rst)
        (any_v && out_btype == 3'd3 && !out_err) |-> out_valid[FW_IDX]);

    a_r7_bad_type: assert property (@(posedge clk) disable iff (rst)
        (any_v && out_btype > 3'd4) |-> out_err);

    a_r11_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !any_v);

endmodule

bind rel_dispatch rel_dispatch_chk #(.ADDR_W(ADDR_W), .NUM_SW(NUM_SW)) u_chk (.*);

// File: tb/test_rel_dispatch.sv
module test_rel_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 40;
    localparam int NUM_SW     = 7;
    localparam int NUM_DEST   = 14;
    localparam int DEST_W     = 4;
    localparam int FW_D       = 5;
    localparam int ERR_D      = 13;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [ADDR_W-1:0]   in_addr = '0;
    logic [3:0]          in_mgr = '0;
    logic [2:0]          in_action = '0;
    logic [2:0]          in_btype = '0;
    logic                in_ovr_valid = 1'b0;
    logic [3:0]          in_ovr_code = '0;
    logic [NUM_DEST-1:0] out_valid;
    logic [NUM_DEST-1:0] out_ready = '1;
    logic [DEST_W-1:0]   out_dest;
    logic [ADDR_W-1:0]   out_addr;
    logic [3:0]          out_mgr;
    logic [2:0]          out_action;
    logic [2:0]          out_btype;
    logic                out_ovr_valid;
    logic [3:0]          out_ovr_code;
    logic                out_err;

    rel_dispatch #(.ADDR_W(ADDR_W), .NUM_SW(NUM_SW)) i_rel_dispatch (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          dest;
        logic [39:0] addr;
        logic [3:0]  mgr;
        logic [2:0]  act;
        logic [2:0]  typ;
        logic        ov;
        logic [3:0]  oc;
        string       req;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  rdy_rand = 1'b0;
    logic [NUM_DEST-1:0] rdy_fixed = '1;

    // expected destination, from the requirements
    function automatic int model(logic [3:0] mgr, logic [2:0] act, logic [2:0] typ,
                                 logic ov, logic [3:0] oc);
        logic [3:0] e;
        logic       lk;
        e  = ov ? oc : mgr;                                   // R5
        lk = (typ == 3'd1) || (typ == 3'd2) || (typ == 3'd4);
        if (e >= 4'd13 || act >= 3'd3 || typ >= 3'd5) return ERR_D;   // R7
        if (typ == 3'd3) return FW_D;                          // R4
        if (e == 4'd0) return (typ == 3'd0 && act == 3'd0) ? 0 : ERR_D; // R1, R6
        if (e == 4'd1 || e == 4'd2 || e == 4'd3 || e == 4'd12) begin   // R2, R6
            if (!lk) return ERR_D;
            if (act == 3'd1 && typ != 3'd1) return ERR_D;
            if (act == 3'd2 && typ != 3'd2) return ERR_D;
            return (e == 4'd12) ? 4 : int'(e);
        end
        if (e == 4'd4) return FW_D;                            // R3
        return 6 + int'(e) - 5;                                // R3
    endfunction

    task automatic chk(input logic ok, input string req, input longint act_v, input longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic send(input logic [39:0] a, input logic [3:0] m, input logic [2:0] ac,
                        input logic [2:0] t, input logic ov, input logic [3:0] oc, input string req);
        item_t it;
        logic  got;
        @(posedge clk); #1;
        in_valid = 1'b1; in_addr = a; in_mgr = m; in_action = ac;
        in_btype = t; in_ovr_valid = ov; in_ovr_code = oc;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            got = in_ready;
        end
        it.dest = model(m, ac, t, ov, oc);
        it.addr = a; it.mgr = m; it.act = ac; it.typ = t; it.ov = ov; it.oc = oc; it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // ready driver
    always @(posedge clk) begin
        #2;
        out_ready = rdy_rand ? (NUM_DEST'($urandom) | NUM_DEST'($urandom)) : rdy_fixed;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(out_valid) > 1)
                chk(1'b0, "R9", longint'(out_valid), 0);
            for (int d = 0; d < NUM_DEST; d++) begin
                if (out_valid[d] && out_ready[d]) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R10", d, -1);
                    end else begin
                        item_t e;
                        logic  ok;
                        e = sb.pop_front();
                        ok = (d == e.dest) && (int'(out_dest) == e.dest) && (out_addr == e.addr)
                          && (out_mgr == e.mgr) && (out_action == e.act) && (out_btype == e.typ)
                          && (out_ovr_valid == e.ov) && (out_ovr_code == e.oc)
                          && (out_err == (e.dest == ERR_D));
                        chk(ok, {e.req, " R8"}, d, e.dest);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == '0, "R11", longint'(out_valid), 0);
        chk(in_ready == 1'b1, "R11", longint'(in_ready), 1);

        // single entry: presented the cycle after acceptance
        send(40'h12_3456_7890, 4'd0, 3'd0, 3'd0, 1'b0, 4'd0, "R1");
        idle();
        @(negedge clk);
        chk(out_valid == NUM_DEST'(1), "R9", longint'(out_valid), 1);
        chk(out_err == 1'b0, "R1", longint'(out_err), 0);

        // link lists, including chip 3 on code 12
        send(40'hA0_0000_0001, 4'd1,  3'd1, 3'd1, 1'b0, 4'd0, "R2");
        send(40'hA0_0000_0002, 4'd2,  3'd2, 3'd2, 1'b0, 4'd0, "R2");
        send(40'hA0_0000_0003, 4'd3,  3'd0, 3'd4, 1'b0, 4'd0, "R2");
        send(40'hA0_0000_0004, 4'd12, 3'd0, 3'd1, 1'b0, 4'd0, "R2");
        // firmware and software rings, action ignored
        send(40'hB0_0000_0004, 4'd4,  3'd2, 3'd0, 1'b0, 4'd0, "R3");
        for (int c = 5; c <= 11; c++)
            send(40'hC0_0000_0000 + 40'(c), 4'(c), 3'(c % 3), 3'(c % 5 == 3 ? 0 : c % 5), 1'b0, 4'd0, "R3");
        // extension descriptors
        send(40'hD0_0000_0001, 4'd0, 3'd0, 3'd3, 1'b0, 4'd0, "R4");
        send(40'hD0_0000_0002, 4'd2, 3'd1, 3'd3, 1'b0, 4'd0, "R4");
        // override
        send(40'hE0_0000_0001, 4'd0, 3'd1, 3'd0, 1'b1, 4'd9,  "R5");
        send(40'hE0_0000_0002, 4'd5, 3'd2, 3'd2, 1'b1, 4'd2,  "R5");
        send(40'hE0_0000_0003, 4'd6, 3'd0, 3'd0, 1'b0, 4'd15, "R5");
        send(40'hE0_0000_0004, 4'd4, 3'd0, 3'd0, 1'b1, 4'd1,  "R5");
        // mismatches
        send(40'hF0_0000_0001, 4'd0,  3'd1, 3'd0, 1'b0, 4'd0, "R6");
        send(40'hF0_0000_0002, 4'd0,  3'd0, 3'd1, 1'b0, 4'd0, "R6");
        send(40'hF0_0000_0003, 4'd1,  3'd0, 3'd0, 1'b0, 4'd0, "R6");
        send(40'hF0_0000_0004, 4'd3,  3'd1, 3'd2, 1'b0, 4'd0, "R6");
        send(40'hF0_0000_0005, 4'd12, 3'd2, 3'd1, 1'b0, 4'd0, "R6");
        // illegal codes
        send(40'hF1_0000_0001, 4'd13, 3'd0, 3'd0, 1'b0, 4'd0,  "R7");
        send(40'hF1_0000_0002, 4'd4,  3'd0, 3'd3, 1'b1, 4'd15, "R7");
        send(40'hF1_0000_0003, 4'd4,  3'd3, 3'd0, 1'b0, 4'd0,  "R7");
        send(40'hF1_0000_0004, 4'd5,  3'd0, 3'd6, 1'b0, 4'd0,  "R7");
        idle();
        repeat (3) @(negedge clk);

        // back-pressure on the firmware ring
        @(posedge clk); #1 rdy_fixed = ~NUM_DEST'(1 << FW_D);
        send(40'h77_0000_0001, 4'd4, 3'd0, 3'd0, 1'b0, 4'd0, "R10");
        fork
            begin
                send(40'h77_0000_0002, 4'd0, 3'd0, 3'd0, 1'b0, 4'd0, "R10");
                idle();
            end
            begin
                repeat (4) @(negedge clk);
                chk(in_ready == 1'b0, "R10", longint'(in_ready), 0);
                chk(out_valid == NUM_DEST'(1 << FW_D), "R10", longint'(out_valid), 1 << FW_D);
                chk(out_addr == 40'h77_0000_0001, "R10", longint'(out_addr), 64'h77_0000_0001);
                @(posedge clk); #1 rdy_fixed = '1;
            end
        join
        repeat (3) @(negedge clk);

        // mixed run with random readies
        rdy_rand = 1'b1;
        for (int k = 0; k < 300; k++) begin
            logic [3:0] m;
            m = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(13, 15)) : 4'($urandom_range(0, 12));
            send({8'h5A, 32'($urandom)}, m, 3'($urandom_range(0, 3)),
                 3'($urandom_range(0, 5)), 1'($urandom_range(0, 3) == 0),
                 4'($urandom_range(0, 14)), "R9");
        end
        idle();
        rdy_rand = 1'b0;
        for (int w = 0; w < 200 && sb.size() != 0; w++) @(negedge clk);
        chk(sb.size() == 0, "R10", sb.size(), 0);
        @(negedge clk);
        chk(out_valid == '0, "R10", longint'(out_valid), 0);
        summary();
        $finish;
    end

endmodule